// File: doc/BRIEF.md
# Packet insertion buffer controller

This block keeps one packet of up to 64 quadlets of 32 bits in a local buffer. Software preloads the packet, and hardware later pulls it out quadlet by quadlet so it can be placed into an outgoing stream. Software fills and inspects the buffer through an access port. The port has its own write pointer and its own read pointer, and each one advances by one per access. A control/status word holds the packet length and a three-bit code that names one of eight downstream target buffers. The same word carries the commands: a reset for each pointer, a pad command, and the insertion enable.

The pad command writes all-ones into every entry from the current write pointer up to the last entry, at one entry per clock. A busy flag is high while the pad runs. When software sets the enable, both pointers return to zero and hardware takes over the read pointer. Hardware requests quadlets one at a time. The block flags the final quadlet of the packet, pulses a completion strobe on the next clock and drops the enable by itself. While the enable is set, software accesses that would move a pointer have no effect.

Top module: `pkt_insert_ctrl`

## Requirements
- R1: After reset the status word `csr_rdata` reads 0, and `fill_busy`, `ins_en`, `ins_last` and `ins_done` are all 0.
- R2: While insertion is disabled and no pad is running, an `acc_wr` stores `acc_wdata` at the write pointer (status bits 29:24) and then advances that pointer. `acc_rdata` always shows the entry at the read pointer (status bits 21:16). An `acc_rd` advances the read pointer. Both pointers wrap from 63 to 0.
- R3: Writing 1 to status bit 30 zeroes the write pointer, and writing 1 to bit 22 zeroes the read pointer, but only while insertion is disabled. While insertion is enabled these bits, `acc_wr` and `acc_rd` change neither the pointers nor the buffer contents. Bits 30 and 22 always read back as 0.
- R4: Writing a status word with bit 6 at 1 while disabled sets the enable (bit 6 and `ins_en`) and zeroes both pointers. Writing bit 6 at 0 clears the enable. Every status write loads the packet size into bits 5:0 and the target code into bits 10:8. The target code also appears on `buf_sel`.
- R5: Writing 1 to bit 7 starts a pad. `fill_busy` goes high on the clock after the write and stays high for 64 minus the write pointer cycles. During that time the entries from the write pointer through 63 become 0xFFFFFFFF. Lower entries and the write pointer itself are unchanged, and bit 7 reads back as 0.
- R6: An `acc_wr` issued while `fill_busy` is high stores nothing and leaves the write pointer unchanged.
- R7: While enabled, `ins_data` shows the entry at the read pointer, and each `ins_req` advances that pointer. `ins_last` is high when the read pointer equals the packet size minus 1, so a size of 0 means 64 quadlets. An `ins_req` with `ins_last` high makes `ins_done` high for exactly the next cycle and clears the enable on that same clock.
- R8: An `ins_req` while insertion is disabled moves no pointer and raises no `ins_done`.
- R9: Bits 31, 23 and 15:11 of the status word read as 0 whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Status word write strobe |
| csr_wdata | input | 32 | Status word write value |
| csr_rdata | output | 32 | Status word read value |
| acc_wr | input | 1 | Access port write strobe |
| acc_wdata | input | 32 | Access port write quadlet |
| acc_rd | input | 1 | Access port read advance strobe |
| acc_rdata | output | 32 | Entry at the read pointer |
| fill_busy | output | 1 | Pad in progress |
| ins_req | input | 1 | Hardware request for the next quadlet |
| ins_data | output | 32 | Quadlet at the read pointer |
| ins_last | output | 1 | Current quadlet is the final one of the packet |
| ins_done | output | 1 | One-cycle strobe after the final quadlet is taken |
| ins_en | output | 1 | Insertion enabled |
| buf_sel | output | 3 | Target buffer code |

## Verification
A status write or an access strobe takes effect at the clock edge that captures it. Every pointer field is therefore sampled one edge after the strobe. `acc_rdata`, `ins_data` and `ins_last` follow the read pointer without delay, so the monitor compares them in the same cycle as each request. `fill_busy` is counted cycle by cycle starting on the clock after the pad command, and the count must equal 64 minus the write pointer. `ins_done` is sampled in the cycle after the final request and again one cycle later to confirm that it is a single pulse.

// File: rtl/pib_pkg.sv
package pib_pkg;
   localparam int CSR_W        = 32;
   localparam int BIT_WPTR_CLR = 30;
   localparam int WPTR_LSB     = 24;
   localparam int BIT_RPTR_CLR = 22;
   localparam int RPTR_LSB     = 16;
   localparam int SEL_LSB      = 8;
   localparam int BIT_PAD      = 7;
   localparam int BIT_ENABLE   = 6;
   localparam int SIZE_LSB     = 0;
   localparam int PTR_FIELD_W  = 6;
   localparam int SEL_FIELD_W  = 3;

   typedef struct packed {
      logic wptr_clr;
      logic rptr_clr;
      logic pad;
      logic enable;
   } csr_cmd_t;
endpackage

// File: rtl/pib_mem.sv
module pib_mem #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6,
   parameter bit RESET_MEM = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   generate
      if (RESET_MEM) begin : g_rst_mem
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (we) begin
               mem_q[waddr] <= wdata;
            end
         end
      end else begin : g_plain_mem
         always_ff @(posedge clk) begin
            if (we) mem_q[waddr] <= wdata;
         end
         logic unused_rst;
         assign unused_rst = rst_n;
      end
   endgenerate

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/pib_fill.sv
module pib_fill #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_idx,
   output logic              busy,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_idx
);
   localparam logic [ADDR_W-1:0] LAST_IDX = '1;

   logic              busy_q;
   logic [ADDR_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (busy_q) begin
         idx_q <= idx_q + ADDR_W'(1);
         if (idx_q == LAST_IDX) busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx_q  <= start_idx;
      end
   end

   assign busy   = busy_q;
   assign wr_en  = busy_q;
   assign wr_idx = idx_q;

   AST_PAD_STOPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && (idx_q == LAST_IDX) |=> !busy_q); // R5
   AST_PAD_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && (idx_q != LAST_IDX) |=> busy_q && (idx_q == $past(idx_q) + ADDR_W'(1))); // R5
endmodule

// File: rtl/pib_ctrl.sv
module pib_ctrl #(
   parameter int ADDR_W = 6,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  pib_pkg::csr_cmd_t cmd,
   input  logic [ADDR_W-1:0] size_in,
   input  logic [SEL_W-1:0]  sel_in,
   input  logic              acc_wr,
   input  logic              acc_rd,
   input  logic              ins_req,
   input  logic              fill_busy,
   output logic [ADDR_W-1:0] wr_ptr,
   output logic [ADDR_W-1:0] rd_ptr,
   output logic              en,
   output logic [ADDR_W-1:0] size,
   output logic [SEL_W-1:0]  sel,
   output logic              last,
   output logic              done,
   output logic              fill_start,
   output logic              sw_we
);
   logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q, size_q;
   logic [SEL_W-1:0]  sel_q;
   logic              en_q, done_q;
   logic              en_set, wclr_ok, rclr_ok, sw_rd_ok, hw_step, finish;
   logic [ADDR_W-1:0] last_idx;

   assign en_set   = csr_wr && cmd.enable && !en_q;
   assign wclr_ok  = csr_wr && cmd.wptr_clr && !en_q;
   assign rclr_ok  = csr_wr && cmd.rptr_clr && !en_q;
   assign sw_we    = acc_wr && !en_q && !fill_busy;
   assign sw_rd_ok = acc_rd && !en_q;
   assign hw_step  = ins_req && en_q;
   assign last_idx = size_q - ADDR_W'(1);
   assign last     = en_q && (rd_ptr_q == last_idx);
   assign finish   = hw_step && last;
   assign fill_start = csr_wr && cmd.pad && !fill_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
      end else if (en_set || wclr_ok) begin
         wr_ptr_q <= '0;
      end else if (sw_we) begin
         wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
      end else if (en_set || rclr_ok) begin
         rd_ptr_q <= '0;
      end else if (sw_rd_ok || hw_step) begin
         rd_ptr_q <= rd_ptr_q + ADDR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         done_q <= 1'b0;
         size_q <= '0;
         sel_q  <= '0;
      end else begin
         done_q <= finish;
         if (finish) begin
            en_q <= 1'b0;
         end else if (csr_wr) begin
            en_q <= cmd.enable;
         end
         if (csr_wr) begin
            size_q <= size_in;
            sel_q  <= sel_in;
         end
      end
   end

   assign wr_ptr = wr_ptr_q;
   assign rd_ptr = rd_ptr_q;
   assign en     = en_q;
   assign size   = size_q;
   assign sel    = sel_q;
   assign done   = done_q;

   AST_WPTR_HELD_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(wr_ptr_q)); // R3
   AST_PTRS_ZERO_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> (wr_ptr_q == '0) && (rd_ptr_q == '0)); // R4
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && ins_req && last |=> done_q && !en_q); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R7
   AST_IDLE_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q && ins_req && !csr_wr && !acc_rd |=> $stable(rd_ptr_q) && !done_q); // R8
endmodule

// File: rtl/pkt_insert_ctrl.sv
module pkt_insert_ctrl #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6,
   parameter int SEL_W     = 3,
   parameter bit RESET_MEM = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              acc_wr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_rd,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              fill_busy,
   input  logic              ins_req,
   output logic [DATA_W-1:0] ins_data,
   output logic              ins_last,
   output logic              ins_done,
   output logic              ins_en,
   output logic [SEL_W-1:0]  buf_sel
);
   import pib_pkg::*;

   generate
      if (ADDR_W < 1 || ADDR_W > PTR_FIELD_W) begin : g_bad_addr_w
         $error("ADDR_W must lie in 1..6 to fit the pointer fields");
      end
      if (SEL_W < 1 || SEL_W > SEL_FIELD_W) begin : g_bad_sel_w
         $error("SEL_W must lie in 1..3 to fit the target field");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be positive");
      end
   endgenerate

   csr_cmd_t          cmd;
   logic [ADDR_W-1:0] wr_ptr, rd_ptr, size;
   logic [SEL_W-1:0]  sel;
   logic              en, fill_start, sw_we;
   logic              pad_we;
   logic [ADDR_W-1:0] pad_idx;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata;
   logic              unused_csr;

   assign cmd.wptr_clr = csr_wdata[BIT_WPTR_CLR];
   assign cmd.rptr_clr = csr_wdata[BIT_RPTR_CLR];
   assign cmd.pad      = csr_wdata[BIT_PAD];
   assign cmd.enable   = csr_wdata[BIT_ENABLE];
   assign unused_csr   = ^{csr_wdata[31], csr_wdata[29:23], csr_wdata[21:11]};

   pib_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .csr_wr     (csr_wr),
      .cmd        (cmd),
      .size_in    (csr_wdata[SIZE_LSB +: ADDR_W]),
      .sel_in     (csr_wdata[SEL_LSB +: SEL_W]),
      .acc_wr     (acc_wr),
      .acc_rd     (acc_rd),
      .ins_req    (ins_req),
      .fill_busy  (fill_busy),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr),
      .en         (en),
      .size       (size),
      .sel        (sel),
      .last       (ins_last),
      .done       (ins_done),
      .fill_start (fill_start),
      .sw_we      (sw_we)
   );

   pib_fill #(.ADDR_W(ADDR_W)) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (fill_start),
      .start_idx (wr_ptr),
      .busy      (fill_busy),
      .wr_en     (pad_we),
      .wr_idx    (pad_idx)
   );

   always_comb begin
      if (pad_we) begin
         mem_we    = 1'b1;
         mem_waddr = pad_idx;
         mem_wdata = '1;
      end else begin
         mem_we    = sw_we;
         mem_waddr = wr_ptr;
         mem_wdata = acc_wdata;
      end
   end

   pib_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_MEM(RESET_MEM)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (rd_ptr),
      .rdata (mem_rdata)
   );

   always_comb begin
      csr_rdata                          = '0;
      csr_rdata[WPTR_LSB +: ADDR_W]      = wr_ptr;
      csr_rdata[RPTR_LSB +: ADDR_W]      = rd_ptr;
      csr_rdata[SEL_LSB +: SEL_W]        = sel;
      csr_rdata[BIT_ENABLE]              = en;
      csr_rdata[SIZE_LSB +: ADDR_W]      = size;
   end

   assign acc_rdata = mem_rdata;
   assign ins_data  = mem_rdata;
   assign ins_en    = en;
   assign buf_sel   = sel;

   AST_PAD_BLOCKS_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_busy && acc_wr && !csr_wr |=> $stable(wr_ptr)); // R6
   AST_LAST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      ins_last |-> ins_en); // R7
endmodule

// File: tb/pkt_insert_ctrl_bench.sv
`timescale 1ns/1ps
module pkt_insert_ctrl_bench;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        acc_wr = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic        acc_rd = 1'b0;
   logic [31:0] acc_rdata;
   logic        fill_busy;
   logic        ins_req = 1'b0;
   logic [31:0] ins_data;
   logic        ins_last, ins_done, ins_en;
   logic [2:0]  buf_sel;

   always #4 clk = ~clk;

   pkt_insert_ctrl u_pkt_insert_ctrl (
      .clk(clk), .rst_n(rst_n),
      .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rd(acc_rd), .acc_rdata(acc_rdata),
      .fill_busy(fill_busy), .ins_req(ins_req), .ins_data(ins_data),
      .ins_last(ins_last), .ins_done(ins_done), .ins_en(ins_en), .buf_sel(buf_sel)
   );

   int checks = 0;
   int failures = 0;
   logic [31:0] model [DEPTH];
   int wp = 0;
   int rp = 0;
   logic [31:0] cfg = '0;

   typedef struct packed { logic [31:0] d; logic l; } exp_t;
   exp_t expq [$];

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic csr_write(logic [31:0] d);
      @(posedge clk); #1;
      csr_wr = 1'b1; csr_wdata = d;
      @(posedge clk); #1;
      csr_wr = 1'b0; csr_wdata = '0;
   endtask

   task automatic acc_write(logic [31:0] d);
      @(posedge clk); #1;
      acc_wr = 1'b1; acc_wdata = d;
      @(posedge clk); #1;
      acc_wr = 1'b0; acc_wdata = '0;
   endtask

   task automatic acc_read(string req);
      @(negedge clk);
      check(req, "acc_rdata", acc_rdata, model[rp]);
      @(posedge clk); #1;
      acc_rd = 1'b1;
      @(posedge clk); #1;
      acc_rd = 1'b0;
      rp = (rp + 1) % DEPTH;
   endtask

   // driver: pushes the expected quadlet for every request it raises
   task automatic stream(int start, int count, int sz);
      for (int k = 0; k < count; k++) begin
         exp_t e;
         int idx;
         @(posedge clk); #1;
         idx = (start + k) % DEPTH;
         e.d = model[idx];
         e.l = (idx == ((sz + DEPTH - 1) % DEPTH));
         expq.push_back(e);
         ins_req = 1'b1;
      end
      @(posedge clk); #1;
      ins_req = 1'b0;
   endtask

   // monitor: pops and compares while hardware is reading
   always @(negedge clk) begin
      if (ins_req && ins_en) begin
         if (expq.size() == 0) begin
            check("R7", "unexpected request", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check("R7", "ins_data", ins_data, e.d);
            check("R7", "ins_last", {31'd0, ins_last}, {31'd0, e.l});
         end
      end
   end

   function automatic logic [31:0] wptr_f(logic [31:0] s);
      return {26'd0, s[29:24]};
   endfunction
   function automatic logic [31:0] rptr_f(logic [31:0] s);
      return {26'd0, s[21:16]};
   endfunction

   initial begin
      #(8 * 150000);
      failures++;
      checks++;
      $display("FAIL R1 watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int cnt;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "csr_rdata", csr_rdata, 32'h0);
      check("R1", "outputs", {28'd0, fill_busy, ins_en, ins_last, ins_done}, 32'h0);

      // R9 reserved bits ignored, R4 field loads
      cfg = 32'h0000_0305;
      csr_write(32'h8080_F800 | cfg);
      @(negedge clk);
      check("R9", "reserved readback", csr_rdata, 32'h0000_0305);
      check("R4", "buf_sel", {29'd0, buf_sel}, 32'd3);

      // R2 writes advance write pointer
      for (int i = 0; i < 8; i++) begin
         model[i] = 32'hA000_0000 + i * 32'h0101_0011;
         acc_write(model[i]);
      end
      wp = 8;
      @(negedge clk);
      check("R2", "wptr after 8 writes", wptr_f(csr_rdata), 32'd8);
      for (int i = 0; i < 3; i++) acc_read("R2");
      @(negedge clk);
      check("R2", "rptr after 3 reads", rptr_f(csr_rdata), 32'd3);

      // R3 read pointer clear while disabled
      csr_write(cfg | (32'd1 << 22));
      rp = 0;
      @(negedge clk);
      check("R3", "rptr cleared", rptr_f(csr_rdata), 32'd0);
      check("R3", "wptr kept", wptr_f(csr_rdata), 32'd8);

      // R5 pad from entry 8
      csr_write(cfg | (32'd1 << 7));
      cnt = 0;
      while (fill_busy) begin
         cnt++;
         @(posedge clk); #1;
      end
      check("R5", "busy cycles", cnt, 32'd56);
      for (int i = 8; i < DEPTH; i++) model[i] = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R5", "wptr unchanged and cmd bits read 0", csr_rdata & 32'hFFC0_FFFF, 32'h0800_0305);
      for (int i = 0; i < DEPTH; i++) acc_read("R5");
      @(negedge clk);
      check("R2", "rptr wrapped", rptr_f(csr_rdata), 32'd0);

      // R6 access write during pad is dropped
      csr_write(cfg | (32'd1 << 7));
      acc_write(32'h1234_5678);
      while (fill_busy) begin
         @(posedge clk); #1;
      end
      @(negedge clk);
      check("R6", "wptr during pad", wptr_f(csr_rdata), 32'd8);
      for (int i = 0; i < 9; i++) acc_read("R6");

      // R3 write pointer clear while disabled
      csr_write(cfg | (32'd1 << 30));
      wp = 0;
      @(negedge clk);
      check("R3", "wptr cleared", wptr_f(csr_rdata), 32'd0);
      for (int i = 0; i < 4; i++) begin
         model[i] = 32'h5500_0000 + i;
         acc_write(model[i]);
      end
      wp = 4;

      // R8 request while disabled
      @(posedge clk); #1 ins_req = 1'b1;
      @(posedge clk); #1 ins_req = 1'b0;
      @(negedge clk);
      check("R8", "rptr kept", rptr_f(csr_rdata), 32'd9);
      check("R8", "no done", {31'd0, ins_done}, 32'd0);

      // R4 enable clears both pointers
      csr_write(cfg | (32'd1 << 6));
      @(negedge clk);
      check("R4", "enabled word", csr_rdata, 32'h0000_0345);
      check("R4", "ins_en", {31'd0, ins_en}, 32'd1);

      // R7 first two quadlets, then R3 gating while enabled
      stream(0, 2, 5);
      csr_write(cfg | (32'd1 << 6) | (32'd1 << 30) | (32'd1 << 22));
      @(posedge clk); #1 acc_rd = 1'b1;
      @(posedge clk); #1 acc_rd = 1'b0;
      acc_write(32'hDEAD_BEEF);
      @(negedge clk);
      check("R3", "rptr held while enabled", rptr_f(csr_rdata), 32'd2);
      check("R3", "wptr held while enabled", wptr_f(csr_rdata), 32'd0);

      // R7 remaining quadlets and completion
      stream(2, 3, 5);
      @(negedge clk);
      check("R7", "done pulse", {31'd0, ins_done}, 32'd1);
      check("R7", "enable cleared", {31'd0, ins_en, 24'd0, csr_rdata[6]}, 32'd0);
      @(negedge clk);
      check("R7", "done single", {31'd0, ins_done}, 32'd0);
      check("R7", "queue drained", expq.size(), 32'd0);
      csr_write(cfg | (32'd1 << 22));
      rp = 0;
      acc_read("R3");

      // R7 size 0 means 64 quadlets
      cfg = 32'h0000_0500;
      csr_write(cfg | (32'd1 << 6));
      @(negedge clk);
      check("R4", "buf_sel 5", {29'd0, buf_sel}, 32'd5);
      stream(0, 64, 0);
      @(negedge clk);
      check("R7", "done after 64", {31'd0, ins_done}, 32'd1);
      check("R7", "enable cleared 64", {31'd0, ins_en}, 32'd0);

      // R4 software abort
      cfg = 32'h0000_0205;
      csr_write(cfg | (32'd1 << 6));
      @(negedge clk);
      check("R4", "enable set again", {31'd0, ins_en}, 32'd1);
      csr_write(cfg);
      @(negedge clk);
      check("R4", "enable cleared by write", csr_rdata, 32'h0000_0205);
      check("R4", "no done on abort", {31'd0, ins_done}, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule